// File: doc/BRIEF.md
# Performance-Monitoring Error Counter with Snapshot

This block adds up parity-mismatch indications from a received section or line overhead check into a running performance-monitoring count. Each valid frame comes with the number of mismatching parity bits in that frame. One mode input chooses whether the count grows by that number or by one for each frame that has any mismatch. A second input chooses whether the count stops at its all-ones value or wraps through zero when it overflows.

A monitoring strobe, normally shared by many counters, triggers the snapshot. On each low-to-high change of the strobe, the running count is copied into a holding register and the running count starts again. The holding register is the only output, and software reads it. With `CNT_W = 16` the block fits a per-frame section check. With `CNT_W = 18` it fits a line check, and the upper two bits and the lower sixteen bits can be read as separate words.

Top module: `pm_err_counter`

## Requirements
- R1: While reset is applied, and after it is released, the holding register reads zero until the first transfer.
- R2: In bit mode (`blk_mode` = 0), each cycle with `frame_vld` = 1 adds `bip_miss` to the running count.
- R3: In block mode (`blk_mode` = 1), each cycle with `frame_vld` = 1 and a nonzero `bip_miss` adds exactly one. A frame with `bip_miss` = 0 adds nothing.
- R4: A cycle with `frame_vld` = 0 adds nothing, whatever the value of `bip_miss`.
- R5: In the first cycle where `pm_strobe` is 1 after having been 0, the running count is copied into `hold_cnt`. The new value appears at the next clock edge.
- R6: `hold_cnt` does not change in any cycle that is not a 0-to-1 edge of `pm_strobe`. A strobe that stays high causes only one transfer.
- R7: In the transfer cycle, the running count restarts from that cycle's own increment, so an error in that frame is kept for the next interval.
- R8: With `sat_en` = 1, an addition that would pass 2^CNT_W-1 leaves the count at 2^CNT_W-1, and the count stays there until the next transfer.
- R9: With `sat_en` = 0, the count wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_vld | input | 1 | Marks a cycle that carries one frame's mismatch count |
| bip_miss | input | INC_W | Number of parity mismatches in this frame |
| blk_mode | input | 1 | 0: count bit errors, 1: count errored frames |
| sat_en | input | 1 | 1: stop at the maximum, 0: wrap |
| pm_strobe | input | 1 | Monitoring strobe; a rising edge triggers a transfer |
| hold_cnt | output | CNT_W | Holding register, read-only snapshot |

## Verification
The rising strobe is sampled at clock edge N, so `hold_cnt` carries the new snapshot after edge N. The bench raises the strobe just after a falling edge and reads `hold_cnt` at the next falling edge. A frame presented before edge N belongs to the snapshot taken at edge N. A frame presented together with the rising strobe belongs to the next snapshot. The bench model applies this same cycle split. Because of this, every check is made half a clock after the edge that should produce the value.

// File: rtl/pm_cnt_pkg.sv
package pm_cnt_pkg;
  typedef enum logic {
    CNT_BITS   = 1'b0,
    CNT_BLOCKS = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/pm_edge_det.sv
module pm_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/pm_incr_sel.sv
module pm_incr_sel #(
  parameter int INC_W = 5
) (
  input  logic             frame_vld,
  input  logic [INC_W-1:0] bip_miss,
  input  logic             blk_mode,
  output logic [INC_W-1:0] incr
);
  import pm_cnt_pkg::*;

  cnt_mode_e mode;
  assign mode = cnt_mode_e'(blk_mode);

  always_comb begin
    incr = '0;
    if (frame_vld) begin
      if (mode == CNT_BLOCKS) incr = {{(INC_W-1){1'b0}}, |bip_miss};
      else                    incr = bip_miss;
    end
  end
endmodule

// File: rtl/pm_accum.sv
module pm_accum #(
  parameter int CNT_W = 18,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] incr,
  input  logic             restart,
  input  logic             sat_en,
  output logic [CNT_W-1:0] acc_q
);
  localparam int PAD = CNT_W - INC_W;

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] acc_n;
  logic             acc_en;

  assign sum = {1'b0, acc_q} + {{(PAD+1){1'b0}}, incr};

  always_comb begin
    acc_en = restart | (|incr);
    if (restart)        acc_n = {{PAD{1'b0}}, incr};
    else if (sum[CNT_W]) acc_n = sat_en ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    else                acc_n = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_n;
  end
endmodule

// File: rtl/pm_err_counter.sv
module pm_err_counter #(
  parameter int CNT_W = 18,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_vld,
  input  logic [INC_W-1:0] bip_miss,
  input  logic             blk_mode,
  input  logic             sat_en,
  input  logic             pm_strobe,
  output logic [CNT_W-1:0] hold_cnt
);
  logic [1:0]       rst_pipe;
  logic             srst_n;
  logic             snap;
  logic [INC_W-1:0] incr_w;
  logic [CNT_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  pm_edge_det u_edge (
    .clk  (clk),
    .rst_n(srst_n),
    .lvl  (pm_strobe),
    .rise (snap)
  );

  pm_incr_sel #(.INC_W(INC_W)) u_incr (
    .frame_vld(frame_vld),
    .bip_miss (bip_miss),
    .blk_mode (blk_mode),
    .incr     (incr_w)
  );

  pm_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
    .clk    (clk),
    .rst_n  (srst_n),
    .incr   (incr_w),
    .restart(snap),
    .sat_en (sat_en),
    .acc_q  (acc_q)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)   hold_cnt <= '0;
    else if (snap) hold_cnt <= acc_q;
  end
endmodule

// File: rtl/pm_err_counter_chk.sv
module pm_err_counter_chk #(
  parameter int CNT_W = 18,
  parameter int INC_W = 5
) (
  input logic             clk,
  input logic             srst_n,
  input logic             pm_strobe,
  input logic             sat_en,
  input logic             blk_mode,
  input logic             frame_vld,
  input logic [INC_W-1:0] incr,
  input logic [CNT_W-1:0] acc_cnt,
  input logic [CNT_W-1:0] hold_cnt
);
  localparam int PAD = CNT_W - INC_W;

  logic strb_d;
  logic rise_c;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) strb_d <= 1'b0;
    else         strb_d <= pm_strobe;
  end
  assign rise_c = pm_strobe & ~strb_d;

  AST_RESET_ZERO: assert property (@(posedge clk) !srst_n |-> hold_cnt == '0); // R1
  AST_NO_VLD_NO_INC: assert property (@(posedge clk) disable iff (!srst_n)
    !frame_vld |-> incr == '0); // R4
  AST_BLOCK_ONE: assert property (@(posedge clk) disable iff (!srst_n)
    blk_mode |-> incr <= 1); // R3
  AST_SNAP_VALUE: assert property (@(posedge clk) disable iff (!srst_n)
    rise_c |=> hold_cnt == $past(acc_cnt)); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!srst_n)
    !rise_c |=> $stable(hold_cnt)); // R6
  AST_RESTART: assert property (@(posedge clk) disable iff (!srst_n)
    rise_c |=> acc_cnt == {{PAD{1'b0}}, $past(incr)}); // R7
  AST_SAT_STAYS: assert property (@(posedge clk) disable iff (!srst_n)
    (sat_en && !rise_c && acc_cnt == {CNT_W{1'b1}}) |=> acc_cnt == {CNT_W{1'b1}}); // R8
endmodule

bind pm_err_counter pm_err_counter_chk #(.CNT_W(CNT_W), .INC_W(INC_W)) u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .pm_strobe(pm_strobe),
  .sat_en   (sat_en),
  .blk_mode (blk_mode),
  .frame_vld(frame_vld),
  .incr     (incr_w),
  .acc_cnt  (acc_q),
  .hold_cnt (hold_cnt)
);

// File: tb/pm_err_counter_bench.sv
module pm_err_counter_bench;
  localparam int CNT_W = 18;
  localparam int INC_W = 5;
  localparam longint MAXV = (64'd1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             frame_vld;
  logic [INC_W-1:0] bip_miss;
  logic             blk_mode;
  logic             sat_en;
  logic             pm_strobe;
  logic [CNT_W-1:0] hold_cnt;

  int     n_run  = 0;
  int     n_fail = 0;
  longint exp_acc = 0;
  bit     done = 1'b0;

  always #2 clk = ~clk;

  pm_err_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_pm_err_counter (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .bip_miss(bip_miss),
    .blk_mode(blk_mode), .sat_en(sat_en), .pm_strobe(pm_strobe), .hold_cnt(hold_cnt)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model_add(input bit vld, input int m);
    longint inc, s;
    inc = !vld ? 0 : (blk_mode ? longint'(m != 0) : longint'(m));
    s = exp_acc + inc;
    if (s > MAXV) s = sat_en ? MAXV : s - (MAXV + 1);
    exp_acc = s;
  endfunction

  // starts and ends at a falling edge
  task automatic send(input bit vld, input int m);
    frame_vld = vld; bip_miss = INC_W'(m);
    model_add(vld, m);
    @(negedge clk);
    frame_vld = 1'b0;
  endtask

  task automatic snap_check(input string tag);
    longint want;
    want = exp_acc;
    pm_strobe = 1'b1;
    exp_acc = 0;
    @(negedge clk);
    chk(tag, hold_cnt, want);
    pm_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset value", hold_cnt, 0);
    snap_check("R1 first snapshot of empty count");
  endtask

  task automatic t_bits;
    blk_mode = 1'b0; sat_en = 1'b0;
    send(1, 3); send(1, 0); send(1, 7); send(0, 5); send(1, 24);
    snap_check("R2 bit sum 34");
    send(0, 31); send(0, 1);
    snap_check("R4 invalid frames ignored");
  endtask

  task automatic t_blocks;
    blk_mode = 1'b1;
    send(1, 3); send(1, 0); send(1, 1); send(1, 24); send(0, 9);
    snap_check("R3 errored frames 3");
    blk_mode = 1'b0;
  endtask

  task automatic t_hold_high;
    longint first;
    send(1, 2);
    first = exp_acc;
    pm_strobe = 1'b1; exp_acc = 0;
    @(negedge clk);
    chk("R5 transfer on rise", hold_cnt, first);
    send(1, 4); send(1, 5);
    chk("R6 held strobe no retransfer", hold_cnt, first);
    repeat (3) @(negedge clk);
    chk("R6 hold stable while high", hold_cnt, first);
    pm_strobe = 1'b0;
    @(negedge clk);
    chk("R6 falling strobe no transfer", hold_cnt, first);
    snap_check("R5 second rise captures 9");
  endtask

  task automatic t_restart;
    send(1, 5);
    pm_strobe = 1'b1; frame_vld = 1'b1; bip_miss = 5'd9;
    @(negedge clk);
    chk("R7 snapshot excludes same-cycle frame", hold_cnt, 5);
    exp_acc = 9;
    pm_strobe = 1'b0; frame_vld = 1'b0;
    @(negedge clk);
    snap_check("R7 same-cycle frame kept");
  endtask

  task automatic t_overflow(input bit sat, input string tag);
    sat_en = sat; blk_mode = 1'b0;
    for (int i = 0; i < 10923; i++) send(1, 24);
    send(1, 24);
    snap_check(tag);
  endtask

  initial begin
    rst_n = 1'b0; frame_vld = 1'b0; bip_miss = '0;
    blk_mode = 1'b0; sat_en = 1'b0; pm_strobe = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 hold zero in reset", hold_cnt, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bits();
    t_blocks();
    t_hold_high();
    t_restart();
    t_overflow(1'b1, "R8 saturate at max");
    t_overflow(1'b0, "R9 wrap modulo");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule